// File: doc/BRIEF.md
# LFPS U2 Exit Qualifier

This block sits between the raw low-frequency periodic signaling (LFPS) detector of a SuperSpeed PHY and the link training state machine. While the link is parked in the U2 low-power state, it decides whether an LFPS burst is long enough to count as a real request to leave U2. When a burst qualifies, the block emits a single-cycle exit pulse.

The minimum burst length is set by a window select input. The short window rejects only very brief noise; its default is 31 cycles, which is 248 ns at 125 MHz. The long window has a default of 1000 cycles, which is 8 us at 125 MHz. The long window lets the link stay in U2 through LFPS glitches, such as those a partner emits while it runs receiver detection.

Both window lengths are parameters counted in clock cycles. The same qualification applies whether the port runs as host or as device. The raw detect is synchronised into the clock domain before it is counted. The window is chosen once per burst, at the cycle in which counting begins.

Top module: `lfps_u2_exit_qual`

## Requirements
- R1: With the short window selected (win_long_i = 0), a burst that is sampled high on at least SHORT_CYCLES (31) consecutive clock edges produces an exit pulse. The pulse is high in the cycle after the (SHORT_CYCLES+2)th edge, counted from the first edge that samples the burst high.
- R2: With the short window selected, a burst sampled high on fewer than SHORT_CYCLES consecutive edges produces no exit pulse.
- R3: With the long window selected (win_long_i = 1), a burst must be sampled high on LONG_CYCLES (1000) consecutive edges. Such a burst produces an exit pulse after the (LONG_CYCLES+2)th edge. A shorter burst, including one that would pass the short window, produces none.
- R4: The exit pulse lasts exactly one cycle, and a burst produces at most one pulse however long it stays high.
- R5: No exit pulse is produced while u2_active_i is low. Dropping u2_active_i in the middle of a burst discards the duration counted so far.
- R6: If u2_active_i rises while the synchronised detect is already high, counting starts at that edge. The pulse is then high in the cycle after the window-length-th edge that samples u2_active_i high.
- R7: The window is captured on the edge where counting begins. A change of win_long_i later in the same burst does not change that burst's threshold.
- R8: exit_o is low while reset is asserted and right after it is released. Out of reset, the captured window holds the long setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lfps_raw_i | input | 1 | Unsynchronised LFPS detect from the PHY |
| u2_active_i | input | 1 | High while the link is in U2; enables qualification |
| win_long_i | input | 1 | Window select: 0 = short window, 1 = long window |
| exit_o | output | 1 | One-cycle pulse marking a valid U2 exit |

## Verification
Bursts of exactly the threshold length and one cycle shorter are applied under each window. These separate a correct compare from an off-by-one compare, and they check that each window resolves to its own threshold. A short burst applied under the long window confirms that glitches are rejected. Bursts far longer than either threshold check that the pulse is not repeated and that the counter does not wrap. Further cases vary the enable: low for a whole burst, dropped mid-burst, and raised mid-burst. These separate a counter that clears on loss of the enable from one that only masks the output. Flipping the window select mid-burst shows whether the threshold is latched or tracks the input live.

// File: rtl/lfps_qual_pkg.sv
package lfps_qual_pkg;
   typedef enum logic {
      WIN_SHORT = 1'b0,
      WIN_LONG  = 1'b1
   } win_e;
endpackage

// File: rtl/lfps_sync.sv
module lfps_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("lfps_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lfps_win_sel.sv
module lfps_win_sel
   import lfps_qual_pkg::*;
#(
   parameter int SHORT_CYCLES = 31,
   parameter int LONG_CYCLES  = 1000,
   parameter int CNT_W        = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             idle_i,
   input  logic             win_long_i,
   output logic [CNT_W-1:0] thr_o
);
   localparam logic [CNT_W-1:0] SHORT_THR = CNT_W'(SHORT_CYCLES);
   localparam logic [CNT_W-1:0] LONG_THR  = CNT_W'(LONG_CYCLES);

   win_e             win_req;
   logic [CNT_W-1:0] thr_q;

   assign win_req = win_e'(win_long_i);

   // The window is free to follow the select only while no count runs.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     thr_q <= LONG_THR;
      else if (idle_i) thr_q <= (win_req == WIN_LONG) ? LONG_THR : SHORT_THR;
   end

   assign thr_o = thr_q;
endmodule

// File: rtl/lfps_dur_cnt.sv
module lfps_dur_cnt #(
   parameter int LIMIT = 1000,
   parameter int CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] SAT = CNT_W'(LIMIT);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cnt_q <= '0;
      else if (!run_i)      cnt_q <= '0;
      else if (cnt_q < SAT) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/lfps_exit_gen.sv
module lfps_exit_gen #(
   parameter int CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] thr_i,
   output logic             exit_o
);
   logic hit;
   logic exit_q;

   // The count passes thr-1 only once per burst because it saturates above it.
   assign hit = run_i && (cnt_i == thr_i - 1'b1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) exit_q <= 1'b0;
      else         exit_q <= hit;
   end

   assign exit_o = exit_q;
endmodule

// File: rtl/lfps_u2_exit_qual.sv
module lfps_u2_exit_qual #(
   parameter int SHORT_CYCLES = 31,
   parameter int LONG_CYCLES  = 1000,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lfps_raw_i,
   input  logic u2_active_i,
   input  logic win_long_i,
   output logic exit_o
);
   localparam int CNT_W = $clog2(LONG_CYCLES + 1);

   generate
      if (SHORT_CYCLES < 2) begin : g_chk_short
         $error("SHORT_CYCLES must be at least 2");
      end
      if (LONG_CYCLES <= SHORT_CYCLES) begin : g_chk_long
         $error("LONG_CYCLES must exceed SHORT_CYCLES");
      end
   endgenerate

   logic             lfps_s;
   logic             run;
   logic [CNT_W-1:0] dur_cnt;
   logic [CNT_W-1:0] thr;

   lfps_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (lfps_raw_i),
      .q_o    (lfps_s)
   );

   assign run = lfps_s && u2_active_i;

   lfps_dur_cnt #(.LIMIT(LONG_CYCLES), .CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .cnt_o  (dur_cnt)
   );

   lfps_win_sel #(
      .SHORT_CYCLES (SHORT_CYCLES),
      .LONG_CYCLES  (LONG_CYCLES),
      .CNT_W        (CNT_W)
   ) u_win (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .idle_i     (dur_cnt == '0),
      .win_long_i (win_long_i),
      .thr_o      (thr)
   );

   lfps_exit_gen #(.CNT_W(CNT_W)) u_exit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .cnt_i  (dur_cnt),
      .thr_i  (thr),
      .exit_o (exit_o)
   );
endmodule

// File: rtl/lfps_u2_exit_qual_chk.sv
module lfps_u2_exit_qual_chk #(
   parameter int LONG_CYCLES = 1000,
   parameter int CNT_W       = 10
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             lfps_raw_i,
   input logic             u2_active_i,
   input logic             exit_o,
   input logic [CNT_W-1:0] cnt
);
   // R4: a pulse never lasts two cycles
   a_r4_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exit_o |=> !exit_o);

   // R5: an exit needs the enable on the edge that raised it
   a_r5_needs_u2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exit_o |-> $past(u2_active_i));

   // R1: the raw detect was high through the synchroniser path behind the pulse
   a_r1_needs_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exit_o |-> $past(lfps_raw_i, 3));

   // R4: the duration counter stays within its saturation limit
   a_r4_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt <= CNT_W'(LONG_CYCLES));

   // R8: no exit while reset is applied
   always @(posedge clk_i) begin
      if (!rst_ni) a_r8_quiet_in_reset: assert (!exit_o);
   end
endmodule

bind lfps_u2_exit_qual lfps_u2_exit_qual_chk #(
   .LONG_CYCLES (LONG_CYCLES),
   .CNT_W       (CNT_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .lfps_raw_i  (lfps_raw_i),
   .u2_active_i (u2_active_i),
   .exit_o      (exit_o),
   .cnt         (dur_cnt)
);

// File: tb/lfps_u2_exit_qual_bench.sv
module lfps_u2_exit_qual_bench;
   localparam int S = 31;
   localparam int L = 1000;

   typedef struct packed {
      logic    win;
      logic    u2;
      int      len;
      int      rise;
      int      fall;
      int      sw;
      int      exp;
      int      req;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b1,  S,     0,  0,  0, S+2,  1},  // R1 exact threshold
      '{1'b0, 1'b1,  S-1,   0,  0,  0, 0,    2},  // R2 one short
      '{1'b0, 1'b1,  200,   0,  0,  0, S+2,  4},  // R4 long burst, one pulse
      '{1'b0, 1'b1,  1,     0,  0,  0, 0,    2},  // R2 single-cycle glitch
      '{1'b1, 1'b1,  L,     0,  0,  0, L+2,  3},  // R3 exact long threshold
      '{1'b1, 1'b1,  L-1,   0,  0,  0, 0,    3},  // R3 one short
      '{1'b1, 1'b1,  S,     0,  0,  0, 0,    3},  // R3 short-window burst rejected
      '{1'b1, 1'b1,  1500,  0,  0,  0, L+2,  4},  // R4 saturating burst
      '{1'b0, 1'b0,  100,   0,  0,  0, 0,    5},  // R5 enable low
      '{1'b0, 1'b1,  500,   0,  20, 0, 0,    5},  // R5 enable drops mid-burst
      '{1'b0, 1'b0,  100,   10, 0,  0, 10+S, 6},  // R6 enable rises mid-burst
      '{1'b1, 1'b1,  200,   0,  0,  10, 0,   7},  // R7 long latched, switch ignored
      '{1'b0, 1'b1,  40,    0,  0,  10, S+2, 7}   // R7 short latched, switch ignored
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic raw = 1'b0;
   logic u2 = 1'b0;
   logic win = 1'b1;
   logic exit_w;
   int   checks = 0;
   int   fails = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   lfps_u2_exit_qual u_lfps_u2_exit_qual (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .lfps_raw_i  (raw),
      .u2_active_i (u2),
      .win_long_i  (win),
      .exit_o      (exit_w)
   );

   task automatic check(input int req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v);
      int pulses = 0;
      int first = 0;
      win = v.win;
      u2 = v.u2;
      raw = 1'b0;
      repeat (5) @(negedge clk);
      check(v.req, exit_w, 0, "idle before burst");
      raw = 1'b1;
      for (int i = 1; i <= v.len + 30; i++) begin
         @(negedge clk);
         if (exit_w) begin
            pulses++;
            if (first == 0) first = i;
         end
         if (i == v.len) raw = 1'b0;
         if (v.rise != 0 && i == v.rise) u2 = 1'b1;
         if (v.fall != 0 && i == v.fall) u2 = 1'b0;
         if (v.sw != 0 && i == v.sw) win = ~v.win;
      end
      check(v.req, pulses, (v.exp != 0) ? 1 : 0, "pulse count");
      check(v.req, first, v.exp, "pulse cycle");
      raw = 1'b0;
      u2 = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(8, exit_w, 0, "exit in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(8, exit_w, 0, "exit after reset");

      for (int k = 0; k < NV; k++) run_vec(VECS[k]);

      // R8: reset applied mid-burst suppresses the exit that was pending
      win = 1'b0;
      u2 = 1'b1;
      raw = 1'b1;
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      begin
         int seen = 0;
         for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (exit_w) seen++;
         end
         check(8, seen, 0, "exit while reset held");
      end
      raw = 1'b0;
      u2 = 1'b0;
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(8, exit_w, 0, "exit after second reset");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule